// File: doc/BRIEF.md
# Port Reset and Clock-Stop Controller

This block turns the reset and power-down control bits of one port into three hardware controls: a reset for the port's control and status register bank, a reset for the port's data path, and an enable for the port's clock gate. A full reset can come from any of three sources: the port's own software reset bit, an active-low hardware reset pin, or a chip-wide global reset bit. These sources are combined by OR. A separate software bit resets the data path only, so the port's configuration is kept. The power-down bit stops the port's clocks. After any full reset the register bank brings that bit back to 1, so the port starts out of service.

Both reset outputs go high as soon as a source goes high, with no clock edge needed. They are released in step with the clock through a synchronizer chain. Software must hold each reset bit high for a minimum time. The controller counts the clock edges for which each bit is seen high. If the bit is released too early, it raises a one-cycle warning on a per-bit flag. The clock enable changes only on a rising clock edge, so a downstream latch-based gate cell can use it without glitches.

Top module: `port_rst_ctrl`

## Requirements
- R1: `reg_rst_o` and `dp_rst_o` go to 1 without waiting for a clock edge whenever `sw_rst_i` is 1, `glb_rst_i` is 1 or `hw_rst_n_i` is 0.
- R2: Once every full-reset source is inactive, `reg_rst_o` stays 1 through the first rising edge and is 0 after the second. The chain depth is `SYNC_STAGES`, default 2.
- R3: `dp_rst_o` is 1 whenever `reg_rst_o` is 1. It is also 1 whenever `sw_dp_rst_i` is 1, and it is released on the second rising edge after both are clear.
- R4: `sw_dp_rst_i` alone leaves `reg_rst_o` at 0 and does not change `clk_en_o`.
- R5: `clk_en_o` is 0 at once whenever `reg_rst_o` is 1.
- R6: While `reg_rst_o` is 0, `clk_en_o` takes the inverse of `pwr_dn_i` at each rising edge. Power-down 1 means the clock is stopped.
- R7: `hold_short_o[0]` concerns `sw_rst_i`. Suppose the bit was sampled high on N consecutive rising edges and is then first sampled low. On that edge the flag goes to 1 if N < MIN_CYC. MIN_CYC is the ceiling of `MIN_HOLD_PS`/`CLK_PERIOD_PS`, which is 20 for 100 ns at 5 ns. If N >= MIN_CYC the flag stays 0.
- R8: `hold_short_o[1]` applies the same rule as R7 to `sw_dp_rst_i`.
- R9: Each `hold_short_o` bit is high for exactly one cycle per early release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| hw_rst_n_i | input | 1 | Hardware reset pin, active low, asynchronous |
| glb_rst_i | input | 1 | Chip-wide full reset bit |
| sw_rst_i | input | 1 | Port software full reset bit |
| sw_dp_rst_i | input | 1 | Port software data-path reset bit |
| pwr_dn_i | input | 1 | Port power-down bit (1 = stop clocks) |
| reg_rst_o | output | 1 | Reset for the port register bank, active high |
| dp_rst_o | output | 1 | Reset for the port data path, active high |
| clk_en_o | output | 1 | Enable for the port clock gate |
| hold_short_o | output | 2 | One-cycle flags: reset bit released too early (bit 0 full, bit 1 data path) |

## Verification
Suppose a synchronizer chain has the wrong depth or a stuck stage. The reset outputs would then be released one edge early or late, or never, and that is visible within two edges of the release. Suppose a hold counter is off by one. The flag would then come up wrong exactly at the boundary hold of 19 or 20 edges, so the bench sweeps every hold length from 1 to 24 on both bits. A wrong clock-enable register shows as `clk_en_o` failing to follow power-down on the next edge, or failing to drop at once on a reset.

// File: rtl/port_rst_pkg.sv
package port_rst_pkg;
   localparam int unsigned NUM_SW_RST = 2;
   typedef enum int unsigned {
      SRC_FULL = 0,
      SRC_DP   = 1
   } sw_rst_idx_e;

   function automatic int unsigned ceil_div(input int unsigned a, input int unsigned b);
      return (a + b - 1) / b;
   endfunction
endpackage

// File: rtl/rst_sync_chain.sv
module rst_sync_chain #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic arst_src,
   output logic rst_o
);
   if (STAGES < 2) begin : g_bad_depth
      $error("rst_sync_chain: STAGES must be at least 2");
   end

   logic [STAGES-1:0] q;

   always_ff @(posedge clk or posedge arst_src) begin
      if (arst_src) q <= '1;
      else          q <= {q[STAGES-2:0], 1'b0};
   end

   assign rst_o = q[STAGES-1];
endmodule

// File: rtl/rst_hold_mon.sv
module rst_hold_mon #(
   parameter int unsigned MIN_CYC = 20
) (
   input  logic clk,
   input  logic arst_n,
   input  logic level_i,
   output logic short_o
);
   if (MIN_CYC < 1) begin : g_bad_min
      $error("rst_hold_mon: MIN_CYC must be at least 1");
   end

   localparam int unsigned CW = $clog2(MIN_CYC + 1);
   localparam logic [CW-1:0] LIM = CW'(MIN_CYC);

   logic [CW-1:0] cnt;
   logic          prev;
   logic          flag;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         cnt  <= '0;
         prev <= 1'b0;
         flag <= 1'b0;
      end else begin
         prev <= level_i;
         flag <= prev && !level_i && (cnt < LIM);
         if (level_i) begin
            if (cnt != LIM) cnt <= cnt + 1'b1;
         end else begin
            cnt <= '0;
         end
      end
   end

   assign short_o = flag;
endmodule

// File: rtl/clk_en_gen.sv
module clk_en_gen (
   input  logic clk,
   input  logic rst_i,
   input  logic pwr_dn_i,
   output logic en_o
);
   logic en_q;

   always_ff @(posedge clk or posedge rst_i) begin
      if (rst_i) en_q <= 1'b0;
      else       en_q <= !pwr_dn_i;
   end

   assign en_o = en_q;
endmodule

// File: rtl/port_rst_ctrl.sv
module port_rst_ctrl
   import port_rst_pkg::*;
#(
   parameter int unsigned CLK_PERIOD_PS = 5000,
   parameter int unsigned MIN_HOLD_PS   = 100000,
   parameter int unsigned SYNC_STAGES   = 2
) (
   input  logic       clk,
   input  logic       hw_rst_n_i,
   input  logic       glb_rst_i,
   input  logic       sw_rst_i,
   input  logic       sw_dp_rst_i,
   input  logic       pwr_dn_i,
   output logic       reg_rst_o,
   output logic       dp_rst_o,
   output logic       clk_en_o,
   output logic [1:0] hold_short_o
);
   if (CLK_PERIOD_PS == 0) begin : g_bad_period
      $error("port_rst_ctrl: CLK_PERIOD_PS must be nonzero");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("port_rst_ctrl: SYNC_STAGES must be at least 2");
   end

   localparam int unsigned MIN_CYC = ceil_div(MIN_HOLD_PS, CLK_PERIOD_PS);

   logic full_src;
   logic dp_src;
   logic [NUM_SW_RST-1:0] sw_bits;

   assign full_src = sw_rst_i | glb_rst_i | !hw_rst_n_i;
   assign dp_src   = full_src | sw_dp_rst_i;

   assign sw_bits[SRC_FULL] = sw_rst_i;
   assign sw_bits[SRC_DP]   = sw_dp_rst_i;

   rst_sync_chain #(.STAGES(SYNC_STAGES)) u_reg_sync (
      .clk(clk), .arst_src(full_src), .rst_o(reg_rst_o)
   );

   rst_sync_chain #(.STAGES(SYNC_STAGES)) u_dp_sync (
      .clk(clk), .arst_src(dp_src), .rst_o(dp_rst_o)
   );

   for (genvar i = 0; i < NUM_SW_RST; i++) begin : g_mon
      rst_hold_mon #(.MIN_CYC(MIN_CYC)) u_mon (
         .clk(clk), .arst_n(hw_rst_n_i), .level_i(sw_bits[i]), .short_o(hold_short_o[i])
      );
   end

   clk_en_gen u_cg (
      .clk(clk), .rst_i(reg_rst_o), .pwr_dn_i(pwr_dn_i), .en_o(clk_en_o)
   );
endmodule

// File: rtl/port_rst_ctrl_chk.sv
module port_rst_ctrl_chk (
   input logic       clk,
   input logic       hw_rst_n_i,
   input logic       glb_rst_i,
   input logic       sw_rst_i,
   input logic       sw_dp_rst_i,
   input logic       pwr_dn_i,
   input logic       reg_rst_o,
   input logic       dp_rst_o,
   input logic       clk_en_o,
   input logic [1:0] hold_short_o
);
   p_src_sets_reg_r1: assert property (@(posedge clk) disable iff (!hw_rst_n_i)
      (sw_rst_i || glb_rst_i) |-> reg_rst_o);

   p_full_implies_dp_r3: assert property (@(posedge clk) disable iff (!hw_rst_n_i)
      reg_rst_o |-> dp_rst_o);

   p_dp_bit_sets_dp_r3: assert property (@(posedge clk) disable iff (!hw_rst_n_i)
      sw_dp_rst_i |-> dp_rst_o);

   p_clk_off_in_reset_r5: assert property (@(posedge clk) disable iff (!hw_rst_n_i)
      reg_rst_o |-> !clk_en_o);

   p_clk_follows_pd_r6: assert property (@(posedge clk) disable iff (!hw_rst_n_i)
      (!$past(reg_rst_o) && !reg_rst_o) |-> (clk_en_o == !$past(pwr_dn_i)));

   p_full_flag_at_release_r7: assert property (@(posedge clk) disable iff (!hw_rst_n_i)
      hold_short_o[0] |-> (!$past(sw_rst_i) && $past(sw_rst_i, 2)));

   p_dp_flag_at_release_r8: assert property (@(posedge clk) disable iff (!hw_rst_n_i)
      hold_short_o[1] |-> (!$past(sw_dp_rst_i) && $past(sw_dp_rst_i, 2)));

   p_flag_one_cycle_r9: assert property (@(posedge clk) disable iff (!hw_rst_n_i)
      (hold_short_o != 2'b00) |=> ((hold_short_o & $past(hold_short_o)) == 2'b00));
endmodule

bind port_rst_ctrl port_rst_ctrl_chk u_chk (
   .clk(clk), .hw_rst_n_i(hw_rst_n_i), .glb_rst_i(glb_rst_i), .sw_rst_i(sw_rst_i),
   .sw_dp_rst_i(sw_dp_rst_i), .pwr_dn_i(pwr_dn_i), .reg_rst_o(reg_rst_o),
   .dp_rst_o(dp_rst_o), .clk_en_o(clk_en_o), .hold_short_o(hold_short_o)
);

// File: tb/port_rst_ctrl_tb_top.sv
`timescale 1ns/1ps
module port_rst_ctrl_tb_top;
   localparam int MIN_CYC = 20;

   logic clk = 1'b0;
   logic hw_rst_n = 1'b0, glb_rst = 1'b0, sw_rst = 1'b0, sw_dp_rst = 1'b0, pwr_dn = 1'b1;
   logic reg_rst, dp_rst, clk_en;
   logic [1:0] hold_short;
   int n_cmp = 0, n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   port_rst_ctrl dut_i (
      .clk(clk), .hw_rst_n_i(hw_rst_n), .glb_rst_i(glb_rst), .sw_rst_i(sw_rst),
      .sw_dp_rst_i(sw_dp_rst), .pwr_dn_i(pwr_dn), .reg_rst_o(reg_rst),
      .dp_rst_o(dp_rst), .clk_en_o(clk_en), .hold_short_o(hold_short)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   initial begin
      #1;
      check("R1 reg_rst in pin reset", reg_rst, 1'b1);
      check("R1 dp_rst in pin reset", dp_rst, 1'b1);
      check("R5 clk_en in reset", clk_en, 1'b0);
      tick(); tick();
      hw_rst_n = 1'b1;
      tick();
      check("R2 reg_rst held after 1 edge", reg_rst, 1'b1);
      check("R3 dp_rst held after 1 edge", dp_rst, 1'b1);
      tick();
      check("R2 reg_rst released after 2 edges", reg_rst, 1'b0);
      check("R3 dp_rst released after 2 edges", dp_rst, 1'b0);
      check("R6 clk_en stays off with power-down", clk_en, 1'b0);

      // R7 sweep of software full-reset hold length
      for (int n = 1; n <= MIN_CYC + 4; n++) begin
         sw_rst = 1'b1;
         #0.5;
         check("R1 reg_rst async on sw_rst", reg_rst, 1'b1);
         #0.5;
         for (int k = 0; k < n; k++) tick();
         check("R3 dp_rst during full reset", dp_rst, 1'b1);
         sw_rst = 1'b0;
         tick();
         check("R7 full hold flag", hold_short[0], (n < MIN_CYC));
         check("R2 reg_rst still held 1 edge after release", reg_rst, 1'b1);
         tick();
         check("R9 full flag drops after one cycle", hold_short[0], 1'b0);
         check("R2 reg_rst released", reg_rst, 1'b0);
      end

      pwr_dn = 1'b0;
      tick();
      check("R6 clk_en on after power-up", clk_en, 1'b1);

      // R8 sweep of data-path reset hold length; also R4
      for (int n = 1; n <= MIN_CYC + 4; n++) begin
         sw_dp_rst = 1'b1;
         #0.5;
         check("R3 dp_rst async on dp bit", dp_rst, 1'b1);
         check("R4 reg_rst unaffected by dp bit", reg_rst, 1'b0);
         #0.5;
         for (int k = 0; k < n; k++) tick();
         check("R4 clk_en unaffected by dp bit", clk_en, 1'b1);
         sw_dp_rst = 1'b0;
         tick();
         check("R8 dp hold flag", hold_short[1], (n < MIN_CYC));
         check("R3 dp_rst held 1 edge after release", dp_rst, 1'b1);
         tick();
         check("R9 dp flag drops after one cycle", hold_short[1], 1'b0);
         check("R3 dp_rst released", dp_rst, 1'b0);
      end

      // global reset: asynchronous assertion, clock enable drops at once
      glb_rst = 1'b1;
      #1;
      check("R1 reg_rst async on global", reg_rst, 1'b1);
      check("R5 clk_en drops at once", clk_en, 1'b0);
      check("R3 dp_rst with global", dp_rst, 1'b1);
      tick();
      glb_rst = 1'b0;
      tick();
      check("R2 reg_rst held after global", reg_rst, 1'b1);
      check("R5 clk_en off while reset", clk_en, 1'b0);
      tick();
      check("R2 reg_rst released after global", reg_rst, 1'b0);
      tick();
      check("R6 clk_en returns", clk_en, 1'b1);
      pwr_dn = 1'b1;
      tick();
      check("R6 clk_en off on power-down", clk_en, 1'b0);
      check("R9 no stray flags", hold_short[0] | hold_short[1], 1'b0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule